// File: doc/BRIEF.md
# Instruction Timing and Decode Controller

This block sequences every instruction of a 16-bit single-accumulator processor. A 4-bit step counter is decoded into sixteen one-hot timing strobes. The three opcode bits of the instruction word are decoded into eight operation lines. From the current step and operation, the block issues the register-load, increment and memory-read strobes that the datapath needs for the fetch phase, operand reads, jumps and the skip-on-zero test.

A run flag gates the whole controller. While the flag is low, the counter holds its step and every strobe is low. While it is high, the counter advances one step per clock. Register-reference and input-output instructions return the counter to step 0 after step 3. For every other operation the counter wraps from step 15 back to step 0. The indirect bit of the instruction word is captured during the fetch phase and qualifies the step-3 decisions. The datapath registers and the memory are outside this block.

Top module: `seq_decode_ctrl`

## Requirements
- R1: Reset puts the counter at step 0. On each clock with `run` high the step advances by one, and it wraps from 15 to 0 unless it is cleared.
- R2: While `run` is high, exactly one bit of `t_strobe` is high, and that bit is `t_strobe[k]` for step k.
- R3: `d_line[n]` is high exactly when instruction bits 14..12 equal n. `ind` takes instruction bit 15 at the clock that ends step 2, is 0 after reset, and holds its value at other times.
- R4: Fetch strobes are issued as follows. Step 0 asserts `ar_from_pc`. Step 1 asserts `ir_from_mem`, `pc_inc` and `mem_read`. Step 2 asserts `ar_from_ir`.
- R5: At step 3 with opcode 7, `rr_exec` is asserted when `ind` is 0 and `io_exec` when `ind` is 1. Either one asserts `sc_clr`, so the next step is 0.
- R6: `dr_from_mem` and `mem_read` are asserted at step 4 for opcodes 0, 1, 2 and 6, and not for any other opcode.
- R7: `pc_from_ar` is asserted at step 4 for opcode 4 and at step 5 for opcode 5, and at no other step or opcode.
- R8: At step 6 with opcode 6, `pc_inc` is asserted only when `dr_zero` is high.
- R9: While `run` is low, the step holds and `t_strobe` and all control strobes are 0. When `run` is raised again, operation resumes at the held step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run flag; low freezes the sequence |
| ir | input | 16 | Current instruction word |
| dr_zero | input | 1 | Data register equals zero |
| t_strobe | output | 16 | One-hot timing strobes T0..T15 |
| d_line | output | 8 | One-hot decoded opcode lines |
| ind | output | 1 | Captured indirect bit |
| ar_from_pc | output | 1 | Load address register from program counter |
| ir_from_mem | output | 1 | Load instruction register from memory |
| ar_from_ir | output | 1 | Load address register from instruction bits 11..0 |
| dr_from_mem | output | 1 | Load data register from memory |
| pc_from_ar | output | 1 | Load program counter from address register |
| pc_inc | output | 1 | Increment program counter |
| rr_exec | output | 1 | Register-reference execute strobe |
| io_exec | output | 1 | Input-output execute strobe |
| sc_clr | output | 1 | Step counter clears at next clock |
| mem_read | output | 1 | Memory read request |

## Verification
Each of the eight opcodes is run through every step, and each step's strobes are compared with the expected values. This shows that operand reads, jumps and the skip test fire only for their own opcode and step. Opcode 7 is run with the indirect bit both clear and set, which separates the register-reference path from the input-output path and confirms the early return to step 0. Opcode 6 is run with `dr_zero` both high and low to isolate the conditional increment. One sequence drops `run` partway through an instruction, which shows that the strobes are frozen and that the sequence resumes at the held step.

// File: rtl/seq_decode_ctrl.sv
module seq_decode_ctrl #(
  parameter int SC_W = 4,
  parameter int OP_W = 3,
  parameter int IR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [IR_W-1:0]      ir,
  input  logic                 dr_zero,
  output logic [(1<<SC_W)-1:0] t_strobe,
  output logic [(1<<OP_W)-1:0] d_line,
  output logic                 ind,
  output logic                 ar_from_pc,
  output logic                 ir_from_mem,
  output logic                 ar_from_ir,
  output logic                 dr_from_mem,
  output logic                 pc_from_ar,
  output logic                 pc_inc,
  output logic                 rr_exec,
  output logic                 io_exec,
  output logic                 sc_clr,
  output logic                 mem_read
);
  localparam int NT = 1 << SC_W;
  localparam int ND = 1 << OP_W;
  localparam int IND_POS = IR_W - 1;
  localparam int OP_LSB = IR_W - 1 - OP_W;
  localparam int OP_RR = ND - 1;

  logic [SC_W-1:0] step;
  logic [OP_W-1:0] opc;

  assign opc = ir[OP_LSB +: OP_W];

  genvar k;
  generate
    for (k = 0; k < NT; k++) begin : g_tdec
      assign t_strobe[k] = run && (step == SC_W'(k));
    end
    for (k = 0; k < ND; k++) begin : g_ddec
      assign d_line[k] = (opc == OP_W'(k));
    end
  endgenerate

  assign ar_from_pc  = t_strobe[0];
  assign ir_from_mem = t_strobe[1];
  assign ar_from_ir  = t_strobe[2];
  assign dr_from_mem = t_strobe[4] & (d_line[0] | d_line[1] | d_line[2] | d_line[6]);
  assign pc_from_ar  = (t_strobe[4] & d_line[4]) | (t_strobe[5] & d_line[5]);
  assign pc_inc      = t_strobe[1] | (t_strobe[6] & d_line[6] & dr_zero);
  assign rr_exec     = t_strobe[3] & d_line[OP_RR] & ~ind;
  assign io_exec     = t_strobe[3] & d_line[OP_RR] & ind;
  assign sc_clr      = rr_exec | io_exec;
  assign mem_read    = ir_from_mem | dr_from_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      ind  <= 1'b0;
    end else if (run) begin
      step <= sc_clr ? '0 : step + 1'b1;
      if (t_strobe[2]) ind <= ir[IND_POS];
    end
  end
endmodule

module seq_decode_ctrl_chk #(
  parameter int SC_W = 4,
  parameter int OP_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic [SC_W-1:0]      step,
  input logic [(1<<SC_W)-1:0] t_strobe,
  input logic [(1<<OP_W)-1:0] d_line,
  input logic                 ar_from_pc,
  input logic                 ir_from_mem,
  input logic                 ar_from_ir,
  input logic                 dr_from_mem,
  input logic                 pc_from_ar,
  input logic                 rr_exec,
  input logic                 io_exec,
  input logic                 sc_clr
);
  assert_step_adv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sc_clr) |=> (step == $past(step) + 1'b1));
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones(t_strobe) == 1));
  assert_dline_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(d_line) == 1);
  assert_fetch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ar_from_pc, ir_from_mem, ar_from_ir}));
  assert_exec_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_exec || io_exec) |=> (step == '0));
  assert_operand_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dr_from_mem |-> t_strobe[4]);
  assert_jump_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_from_ar |-> ((t_strobe[4] && d_line[4]) || (t_strobe[5] && d_line[5])));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(step));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (t_strobe == '0 && !pc_from_ar && !dr_from_mem && !sc_clr));
endmodule

bind seq_decode_ctrl seq_decode_ctrl_chk #(.SC_W(SC_W), .OP_W(OP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .step(step), .t_strobe(t_strobe),
  .d_line(d_line), .ar_from_pc(ar_from_pc), .ir_from_mem(ir_from_mem),
  .ar_from_ir(ar_from_ir), .dr_from_mem(dr_from_mem), .pc_from_ar(pc_from_ar),
  .rr_exec(rr_exec), .io_exec(io_exec), .sc_clr(sc_clr)
);

// File: tb/test_seq_decode_ctrl.sv
module test_seq_decode_ctrl;
  logic clk = 0, rst_n = 0, run = 0, dr_zero = 0;
  logic [15:0] ir = '0;
  logic [15:0] t_strobe;
  logic [7:0] d_line;
  logic ind, ar_from_pc, ir_from_mem, ar_from_ir, dr_from_mem, pc_from_ar;
  logic pc_inc, rr_exec, io_exec, sc_clr, mem_read;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  seq_decode_ctrl i_seq_decode_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .ir(ir), .dr_zero(dr_zero),
    .t_strobe(t_strobe), .d_line(d_line), .ind(ind), .ar_from_pc(ar_from_pc),
    .ir_from_mem(ir_from_mem), .ar_from_ir(ar_from_ir), .dr_from_mem(dr_from_mem),
    .pc_from_ar(pc_from_ar), .pc_inc(pc_inc), .rr_exec(rr_exec), .io_exec(io_exec),
    .sc_clr(sc_clr), .mem_read(mem_read)
  );

  function automatic logic [9:0] ctl_now();
    return {ar_from_pc, ir_from_mem, ar_from_ir, dr_from_mem, pc_from_ar,
            pc_inc, rr_exec, io_exec, sc_clr, mem_read};
  endfunction

  // expected strobes for step k derived from R4..R8
  function automatic logic [9:0] ctl_exp(int k, logic [15:0] w, logic dz);
    int op = int'(w[14:12]);
    logic rd, pa, pi, rr, io;
    rd = (k == 4) && (op == 0 || op == 1 || op == 2 || op == 6);
    pa = (k == 4 && op == 4) || (k == 5 && op == 5);
    pi = (k == 1) || (k == 6 && op == 6 && dz);
    rr = (k == 3) && (op == 7) && !w[15];
    io = (k == 3) && (op == 7) && w[15];
    return {k == 0, k == 1, k == 2, rd, pa, pi, rr, io, rr | io, (k == 1) | rd};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    rst_n = 0; run = 1;
    step();
    rst_n = 1;
  endtask

  task automatic test_reset();
    run = 0; rst_n = 0; ir = 16'h0000;
    step();
    chk(t_strobe == 16'h0 && ctl_now() == 10'h0 && ind == 0, "R9 reset idle", {t_strobe, 6'd0, ctl_now()}, 0);
    rst_n = 1; run = 1;
    #1;
    chk(t_strobe == 16'h0001, "R1 reset step 0", t_strobe, 16'h0001);
  endtask

  task automatic run_instr(input logic [15:0] w, input logic dz, input string req);
    int last;
    ir = w; dr_zero = dz;
    do_reset();
    last = (w[14:12] == 3'd7) ? 3 : 15;
    for (int k = 0; k <= last; k++) begin
      chk(t_strobe == (16'h1 << k), {req, " R2 strobe"}, t_strobe, 16'h1 << k);
      chk(ctl_now() == ctl_exp(k, w, dz), req, ctl_now(), ctl_exp(k, w, dz));
      if (k == 3)
        chk(ind == w[15], "R3 indirect capture", ind, w[15]);
      step();
    end
    chk(t_strobe == 16'h0001, {req, " R1 next step 0"}, t_strobe, 16'h0001);
  endtask

  task automatic test_decode();
    for (int n = 0; n < 8; n++) begin
      ir = {1'b0, 3'(n), 12'hABC};
      #1;
      chk(d_line == (8'h1 << n), "R3 opcode decode", d_line, 8'h1 << n);
    end
  endtask

  task automatic test_hold();
    ir = 16'h5123; dr_zero = 0;
    do_reset();
    for (int k = 0; k < 5; k++) step();
    run = 0; #1;
    chk(t_strobe == 16'h0 && ctl_now() == 10'h0, "R9 frozen outputs", {t_strobe, 6'd0, ctl_now()}, 0);
    for (int k = 0; k < 3; k++) step();
    chk(t_strobe == 16'h0 && pc_from_ar == 0, "R9 still frozen", t_strobe, 0);
    run = 1; #1;
    chk(t_strobe == 16'h0020 && pc_from_ar == 1, "R9 resume at step 5 R7", {t_strobe, 15'd0, pc_from_ar}, {16'h0020, 16'h1});
    step();
    chk(t_strobe == 16'h0040, "R1 advance after resume", t_strobe, 16'h0040);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3;
    test_reset();
    test_decode();
    for (int n = 0; n < 8; n++)
      if (n != 6 && n != 7) run_instr({1'b0, 3'(n), 12'h123}, 1'b0, "R4 R6 R7 op sweep");
    run_instr(16'h8123, 1'b1, "R6 indirect operand read");
    run_instr(16'h6040, 1'b1, "R8 skip taken");
    run_instr(16'h6040, 1'b0, "R8 skip not taken");
    run_instr(16'h7800, 1'b0, "R5 register-reference");
    run_instr(16'hF400, 1'b0, "R5 input-output");
    test_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule